// File: doc/BRIEF.md
# Masked Address Breakpoint Unit

This unit watches the instruction fetches and data accesses of a CPU and raises a break request when one of its programmed comparators matches. It has four instruction-side comparators and two data-side comparators. Every comparator holds a virtual address, a don't-care mask and an optional address-space tag, and has its own enable bits. A data comparator can also require the transferred value to match, with chosen bytes left out of that comparison. Comparison uses only the virtual address presented with the access. No physical address takes part.

A debugger programs the comparators through a small read/write register port. Each comparator that fires sets its own sticky bit in the instruction-side or data-side status word. The unit also pulses a break request for the matching side in the cycle after the access. Software clears status bits by writing ones to them.

Register map (7-bit `cfg_addr`):
- Bit 6 = 0 selects a comparator.
  - Bit 5 picks the side: 0 = instruction, 1 = data.
  - Bits 4:3 pick the comparator index.
  - Bits 2:0 pick the field: 0 address, 1 mask, 2 tag, 3 control, 4 value.
- Address 0x40 is the instruction status word and 0x41 is the data status word.

Control bits:
- Bit 0: enable. On a data comparator this enables matching on loads.
- Bit 1: enable on stores (data comparators only).
- Bit 2: require a tag match.
- Bit 3: require a value match (data comparators only).
- Bits 7:4: lane exclusions. Bit 4+k excludes byte k, meaning data bits 8k+7:8k.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, both status words read 0, both break outputs are low, every control field reads 0, and no access produces a hit.
- R2: An instruction comparator with control bit 0 set hits on a fetch whose address equals its programmed address on every bit that is not masked. The hit sets instruction status bit i (i = comparator index), and `brk_instr` is high in the cycle after the fetch.
- R3: Each address mask bit set to 1 removes that address bit from the comparison. A fetch that differs only in masked bits still hits, and a difference in an unmasked bit prevents the hit.
- R4: With control bit 2 set, a comparator hits only when `cur_asid` equals its programmed tag. With control bit 2 clear, the tag value is ignored.
- R5: A data comparator hits on loads (`da_store`=0) only if control bit 0 is set, and on stores (`da_store`=1) only if control bit 1 is set. A hit sets data status bit j and raises `brk_data` in the next cycle.
- R6: With control bit 3 set, a data comparator also requires `da_data` to equal its programmed value in every byte k whose control bit 4+k is 0. Bytes with control bit 4+k set are ignored.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A hit in the same cycle as the clear leaves the bit set.
- R8: In the data status word, every bit above bit 1 reads 0, including bits 29 and 28.
- R9: The address, mask, tag, control and value fields read back exactly the value last written to them.
- R10: Several comparators hitting on the same access each set their own status bit.
- R11: A break output is high for exactly one cycle per hitting access. It is low in the cycle after an access that hits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register address |
| cfg_wdata | input | XLEN | Register write data |
| cfg_rdata | output | XLEN | Register read data (combinational) |
| cur_asid | input | ASW | Current address-space tag |
| if_valid | input | 1 | Instruction fetch presented |
| if_vaddr | input | XLEN | Fetch virtual address |
| da_valid | input | 1 | Data access presented |
| da_store | input | 1 | 1 = store, 0 = load |
| da_vaddr | input | XLEN | Data virtual address |
| da_data | input | XLEN | Loaded or stored value |
| brk_instr | output | 1 | Instruction break request |
| brk_data | output | 1 | Data break request |

## Verification
On every cycle the assertions check several properties:
- a hit sets its status bit on the next edge;
- a status bit stays set unless a write of one clears it;
- each break output follows a hit on its side, cycle by cycle;
- a hit with the tag qualifier on always carries the matching tag;
- a data hit always agrees with the load or store enable.

Only the directed scenarios can show the content of the match itself, by driving accesses that should and should not match. These scenarios cover masked bits, excluded byte lanes, the priority of a hit over a clear, readback of the fields, and the zero upper bits of the data status word.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int CTL_W     = 8;
  localparam int CTL_EN_LD = 0;
  localparam int CTL_EN_ST = 1;
  localparam int CTL_ASID  = 2;
  localparam int CTL_VAL   = 3;
  localparam int CTL_LANE  = 4;

  typedef enum logic [2:0] {
    F_ADDR = 3'd0,
    F_MASK = 3'd1,
    F_ASID = 3'd2,
    F_CTRL = 3'd3,
    F_VAL  = 3'd4
  } fld_e;
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ASW     = 8,
  parameter bit IS_DATA = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [2:0]      fsel,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  input  logic            acc_valid,
  input  logic            acc_store,
  input  logic [XLEN-1:0] acc_addr,
  input  logic [ASW-1:0]  acc_asid,
  input  logic [XLEN-1:0] acc_data,
  output logic            hit
);
  localparam int NB = XLEN / 8;

  logic [XLEN-1:0]  addr_q, addr_d, mask_q, mask_d, val_q;
  logic [ASW-1:0]   asid_q, asid_d;
  logic [CTL_W-1:0] ctrl_q, ctrl_d;
  logic             addr_ok, asid_ok, en_ok, val_ok;

  always_comb begin
    addr_d = addr_q;
    mask_d = mask_q;
    asid_d = asid_q;
    ctrl_d = ctrl_q;
    if (we) begin
      case (fsel)
        F_ADDR:  addr_d = wdata;
        F_MASK:  mask_d = wdata;
        F_ASID:  asid_d = wdata[ASW-1:0];
        F_CTRL:  ctrl_d = wdata[CTL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
      asid_q <= '0;
      ctrl_q <= '0;
    end else begin
      addr_q <= addr_d;
      mask_q <= mask_d;
      asid_q <= asid_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign addr_ok = ((acc_addr ^ addr_q) & ~mask_q) == '0;
  assign asid_ok = !ctrl_q[CTL_ASID] || (acc_asid == asid_q);

  generate
    if (IS_DATA) begin : g_data
      logic [XLEN-1:0] val_d;
      logic [NB-1:0]   lane_ok;

      always_comb begin
        val_d = val_q;
        if (we && fsel == F_VAL) val_d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
      end

      for (genvar k = 0; k < NB; k++) begin : g_lane
        assign lane_ok[k] = ctrl_q[CTL_LANE+k] ||
                            (acc_data[8*k +: 8] == val_q[8*k +: 8]);
      end

      assign en_ok  = acc_store ? ctrl_q[CTL_EN_ST] : ctrl_q[CTL_EN_LD];
      assign val_ok = !ctrl_q[CTL_VAL] || (&lane_ok);

      a_r5_dir_enable: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (acc_store ? ctrl_q[CTL_EN_ST] : ctrl_q[CTL_EN_LD]));
    end else begin : g_instr
      logic unused_ok;
      assign val_q     = '0;
      assign en_ok     = ctrl_q[CTL_EN_LD];
      assign val_ok    = 1'b1;
      assign unused_ok = ^{acc_store, acc_data};
    end
  endgenerate

  assign hit = acc_valid && en_ok && addr_ok && asid_ok && val_ok;

  always_comb begin
    case (fsel)
      F_ADDR:  rdata = addr_q;
      F_MASK:  rdata = mask_q;
      F_ASID:  rdata = XLEN'(asid_q);
      F_CTRL:  rdata = XLEN'(ctrl_q);
      F_VAL:   rdata = val_q;
      default: rdata = '0;
    endcase
  end

  a_r4_asid_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl_q[CTL_ASID]) |-> (acc_asid == asid_q));
endmodule

// File: rtl/bkpt_status.sv
module bkpt_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] stat_q,
  output logic         brk_q
);
  logic [N-1:0] stat_d;
  logic         brk_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_we) stat_d = stat_d & ~clr_bits;
    stat_d = stat_d | hit;
    brk_d  = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      brk_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      brk_q  <= brk_d;
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      a_r2_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit[i] |=> stat_q[i]);
      a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[i] && !(clr_we && clr_bits[i])) |=> stat_q[i]);
    end
  endgenerate

  a_r11_brk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit) |=> !brk_q);
  a_r2_brk_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> brk_q);
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ASW  = 8,
  parameter int NI   = 4,
  parameter int ND   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [6:0]      cfg_addr,
  input  logic [XLEN-1:0] cfg_wdata,
  output logic [XLEN-1:0] cfg_rdata,
  input  logic [ASW-1:0]  cur_asid,
  input  logic            if_valid,
  input  logic [XLEN-1:0] if_vaddr,
  input  logic            da_valid,
  input  logic            da_store,
  input  logic [XLEN-1:0] da_vaddr,
  input  logic [XLEN-1:0] da_data,
  output logic            brk_instr,
  output logic            brk_data
);
  localparam int IDXW = 2;

  logic [1:0]      rst_sync;
  logic            rst_s;
  logic            is_stat, side;
  logic [IDXW-1:0] idx;
  logic [2:0]      fsel;
  logic            istat_we, dstat_we;
  logic [NI-1:0]   ihit, istat;
  logic [ND-1:0]   dhit, dstat;
  logic [XLEN-1:0] ird [NI];
  logic [XLEN-1:0] drd [ND];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign is_stat  = cfg_addr[6];
  assign side     = cfg_addr[5];
  assign idx      = cfg_addr[4:3];
  assign fsel     = cfg_addr[2:0];
  assign istat_we = cfg_we && is_stat && cfg_addr[5:0] == 6'd0;
  assign dstat_we = cfg_we && is_stat && cfg_addr[5:0] == 6'd1;

  generate
    for (genvar i = 0; i < NI; i++) begin : g_icmp
      bkpt_cmp #(.XLEN(XLEN), .ASW(ASW), .IS_DATA(1'b0)) u_cmp (
        .clk(clk), .rst_n(rst_s),
        .we(cfg_we && !is_stat && !side && idx == IDXW'(i)),
        .fsel(fsel), .wdata(cfg_wdata), .rdata(ird[i]),
        .acc_valid(if_valid), .acc_store(1'b0), .acc_addr(if_vaddr),
        .acc_asid(cur_asid), .acc_data('0), .hit(ihit[i]));
    end
    for (genvar j = 0; j < ND; j++) begin : g_dcmp
      bkpt_cmp #(.XLEN(XLEN), .ASW(ASW), .IS_DATA(1'b1)) u_cmp (
        .clk(clk), .rst_n(rst_s),
        .we(cfg_we && !is_stat && side && idx == IDXW'(j)),
        .fsel(fsel), .wdata(cfg_wdata), .rdata(drd[j]),
        .acc_valid(da_valid), .acc_store(da_store), .acc_addr(da_vaddr),
        .acc_asid(cur_asid), .acc_data(da_data), .hit(dhit[j]));
    end
  endgenerate

  bkpt_status #(.N(NI)) u_istat (
    .clk(clk), .rst_n(rst_s), .hit(ihit), .clr_we(istat_we),
    .clr_bits(cfg_wdata[NI-1:0]), .stat_q(istat), .brk_q(brk_instr));

  bkpt_status #(.N(ND)) u_dstat (
    .clk(clk), .rst_n(rst_s), .hit(dhit), .clr_we(dstat_we),
    .clr_bits(cfg_wdata[ND-1:0]), .stat_q(dstat), .brk_q(brk_data));

  always_comb begin
    cfg_rdata = '0;
    if (is_stat) begin
      if (cfg_addr[5:0] == 6'd0)      cfg_rdata = XLEN'(istat);
      else if (cfg_addr[5:0] == 6'd1) cfg_rdata = XLEN'(dstat);
    end else if (!side) begin
      for (int k = 0; k < NI; k++) if (idx == IDXW'(k)) cfg_rdata = ird[k];
    end else begin
      for (int k = 0; k < ND; k++) if (idx == IDXW'(k)) cfg_rdata = drd[k];
    end
  end
endmodule

// File: tb/bkpt_unit_tb.sv
`timescale 1ns/1ps
module bkpt_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [7:0]  cur_asid;
  logic        if_valid, da_valid, da_store;
  logic [31:0] if_vaddr, da_vaddr, da_data;
  logic        brk_instr, brk_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bkpt_unit u_dut (.*);

  localparam logic [6:0] ISTAT = 7'h40, DSTAT = 7'h41;

  function automatic logic [6:0] ra(input bit d, input int i, input int f);
    return {1'b0, d, 2'(i), 3'(f)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
    @(negedge clk); cfg_addr = a; #2;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic prog(input bit d, input int i, input logic [31:0] ad,
                      input logic [31:0] mk, input logic [7:0] asid, input logic [7:0] ctl);
    wr(ra(d, i, 0), ad); wr(ra(d, i, 1), mk);
    wr(ra(d, i, 2), {24'd0, asid}); wr(ra(d, i, 3), {24'd0, ctl});
  endtask

  task automatic fetch(input string req, input logic [31:0] a, input logic [7:0] asid,
                       input bit exp_brk);
    @(negedge clk); if_valid = 1'b1; if_vaddr = a; cur_asid = asid;
    @(negedge clk); if_valid = 1'b0;
    chk(req, {31'd0, brk_instr}, {31'd0, exp_brk});
    @(negedge clk);
    chk({req, " pulse"}, {31'd0, brk_instr}, 32'd0);
  endtask

  task automatic access(input string req, input bit st, input logic [31:0] a,
                        input logic [31:0] d, input bit exp_brk);
    @(negedge clk); da_valid = 1'b1; da_store = st; da_vaddr = a; da_data = d;
    @(negedge clk); da_valid = 1'b0;
    chk(req, {31'd0, brk_data}, {31'd0, exp_brk});
  endtask

  task automatic clear_all();
    wr(ISTAT, 32'hFFFF_FFFF); wr(DSTAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    rd_chk("R1 istat", ISTAT, 0);
    rd_chk("R1 dstat", DSTAT, 0);
    rd_chk("R1 ctrl", ra(0, 2, 3), 0);
    chk("R1 brk", {30'd0, brk_instr, brk_data}, 0);
    fetch("R1 no hit", 32'h0, 8'h0, 1'b0);
    rd_chk("R1 istat after fetch", ISTAT, 0);
  endtask

  task automatic t_readback();
    prog(1, 1, 32'hDEAD_BEEC, 32'h0000_00F0, 8'h5A, 8'hA5);
    wr(ra(1, 1, 4), 32'h1234_5678);
    rd_chk("R9 addr", ra(1, 1, 0), 32'hDEAD_BEEC);
    rd_chk("R9 mask", ra(1, 1, 1), 32'h0000_00F0);
    rd_chk("R9 asid", ra(1, 1, 2), 32'h5A);
    rd_chk("R9 ctrl", ra(1, 1, 3), 32'hA5);
    rd_chk("R9 value", ra(1, 1, 4), 32'h1234_5678);
    wr(ra(1, 1, 3), 0);
  endtask

  task automatic t_exact();
    prog(0, 0, 32'h0000_1000, 0, 0, 8'h01);
    fetch("R2 exact hit", 32'h0000_1000, 8'h3, 1'b1);
    rd_chk("R2 istat bit0", ISTAT, 32'h1);
    clear_all();
    fetch("R11 miss", 32'h0000_1004, 8'h3, 1'b0);
    rd_chk("R11 istat clean", ISTAT, 0);
  endtask

  task automatic t_mask();
    prog(0, 1, 32'h0000_2000, 32'h0000_00FF, 0, 8'h01);
    fetch("R3 masked hit", 32'h0000_20F4, 8'h0, 1'b1);
    rd_chk("R3 istat bit1", ISTAT, 32'h2);
    clear_all();
    fetch("R3 unmasked miss", 32'h0000_2100, 8'h0, 1'b0);
  endtask

  task automatic t_asid();
    prog(0, 2, 32'h0000_3000, 0, 8'h05, 8'h05);
    fetch("R4 asid match", 32'h0000_3000, 8'h05, 1'b1);
    clear_all();
    fetch("R4 asid mismatch", 32'h0000_3000, 8'h06, 1'b0);
    prog(0, 3, 32'h0000_4000, 0, 8'h05, 8'h01);
    fetch("R4 asid ignored", 32'h0000_4000, 8'h09, 1'b1);
    rd_chk("R4 istat bit3", ISTAT, 32'h8);
    clear_all();
  endtask

  task automatic t_multi();
    prog(0, 0, 32'h0000_5000, 0, 0, 8'h01);
    prog(0, 1, 32'h0000_5000, 32'h0000_0F00, 0, 8'h01);
    fetch("R10 two hits", 32'h0000_5000, 8'h0, 1'b1);
    rd_chk("R10 istat bits", ISTAT, 32'h3);
  endtask

  task automatic t_w1c();
    wr(ISTAT, 32'h1);
    rd_chk("R7 w1c clears only bit0", ISTAT, 32'h2);
    wr(ISTAT, 32'h0);
    rd_chk("R7 zero write keeps", ISTAT, 32'h2);
    @(negedge clk);
    if_valid = 1'b1; if_vaddr = 32'h0000_5000;
    cfg_we = 1'b1; cfg_addr = ISTAT; cfg_wdata = 32'h3;
    @(negedge clk); if_valid = 1'b0; cfg_we = 1'b0;
    rd_chk("R7 hit beats clear", ISTAT, 32'h3);
    clear_all();
    rd_chk("R7 cleared", ISTAT, 0);
  endtask

  task automatic t_data_dir();
    prog(1, 0, 32'h0000_8000, 0, 0, 8'h01);
    access("R5 load hit", 1'b0, 32'h0000_8000, 32'h0, 1'b1);
    rd_chk("R5 dstat bit0", DSTAT, 32'h1);
    clear_all();
    access("R5 store miss", 1'b1, 32'h0000_8000, 32'h0, 1'b0);
    rd_chk("R5 dstat clean", DSTAT, 0);
  endtask

  task automatic t_value();
    prog(1, 1, 32'h0000_9000, 0, 0, 8'h1B);
    wr(ra(1, 1, 4), 32'h1122_3344);
    access("R6 lane0 excluded hit", 1'b1, 32'h0000_9000, 32'h1122_33FF, 1'b1);
    rd_chk("R6 dstat bit1", DSTAT, 32'h2);
    clear_all();
    access("R6 value miss", 1'b1, 32'h0000_9000, 32'h1022_3344, 1'b0);
    access("R6 load value hit", 1'b0, 32'h0000_9000, 32'h1122_3300, 1'b1);
  endtask

  task automatic t_dstat_hi();
    access("R8 load hit dc0", 1'b0, 32'h0000_8000, 32'h0, 1'b1);
    rd_chk("R8 upper bits zero", DSTAT, 32'h3);
    clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; cur_asid = 0;
    if_valid = 0; if_vaddr = 0; da_valid = 0; da_store = 0; da_vaddr = 0; da_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_readback();
    t_exact();
    t_mask();
    t_asid();
    t_multi();
    t_w1c();
    t_data_dir();
    t_value();
    t_dstat_hi();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule